// File: doc/BRIEF.md
# Trap and Debug Entry Controller

This block decides where execution continues when the pipeline reports an exception. It owns the program counter redirect target, the current privilege level, the machine trap-vector register, the debug state (debug cause, saved privilege, debug PC) and two save banks of exception PC, cause and faulting address. One bank serves machine-level traps and the other serves traps delegated to supervisor level.

Three routes are possible for an exception, tested in this fixed order:
- A software breakpoint whose per-privilege enable bit is set diverts into debug mode.
- Any other exception raised while a debug cause is already recorded jumps to a fixed debug-exception address and leaves all other state alone.
- Otherwise the exception is a normal trap. It goes to supervisor level when its delegation bit is set and the hart is below machine level, and to machine level in every other case.

All updates for an exception take effect on the clock edge that samples the exception pulse. A one-cycle redirect strobe is raised together with the new PC. A write port loads the machine trap vector, and a privilege load port lets the surrounding core change level (for example on a return instruction).

Top module: `trap_debug_entry`

## Requirements
- R1: After reset, `pc_o` equals RESET_VEC (default 0x1000), `priv_o` is 3 (machine), `mtvec_o` equals MTVEC_DEF (default 0x100), `dbg_cause_o`, `dbg_prv_o`, `dpc_o` and all save-bank outputs are 0, and `redirect_o` is low.
- R2: `redirect_o` is high in the cycle after an edge that samples `exc_valid_i` high, and low otherwise. With no exception and no privilege load, `pc_o` and `priv_o` hold their values.
- R3: An exception with cause BRK_CAUSE (default 3), while `ebreak_en_i[priv_o]` is set, enters debug mode. The privilege encoding is U=0, S=1, H=2, M=3. On entry, `dbg_cause_o` becomes 1, `dbg_prv_o` takes the old privilege, `priv_o` becomes 3, `dpc_o` takes `cur_pc_i`, `pc_o` becomes DBG_START (default 0x800), and neither save bank changes.
- R4: A breakpoint cause whose enable bit for the current privilege is clear is handled as a normal trap.
- R5: An exception that is not a debug entry, taken while `dbg_cause_o` is nonzero, sets `pc_o` to DBG_EXC (default 0x808). It changes no privilege, debug field or save bank.
- R6: A normal trap that is not delegated sets `pc_o` to the old `mtvec_o` and `priv_o` to 3. It also writes `exc_epc_i` to `mepc_o` and the cause to `mcause_o`. `mbadaddr_o` takes `bad_addr_i` only when `bad_valid_i` is high.
- R7: A normal trap whose bit `medeleg_i[cause]` is set, taken at privilege 0 or 1, sets `pc_o` to `stvec_i`, sets `priv_o` to 1, and writes `sepc_o` and `scause_o`. `sbadaddr_o` is written only when `bad_valid_i` is high. The machine bank is unchanged. At privilege 2 or 3 the trap stays at machine level.
- R8: The breakpoint test comes before the debug-cause test. An enabled breakpoint taken while already in debug mode re-enters debug mode, refreshing `dpc_o` and `dbg_prv_o`.
- R9: A write to the trap vector stores `mtvec_wdata_i` with bits 1:0 cleared. A trap in the same cycle as the write uses the old vector.
- R10: `priv_we_i` loads `priv_wdata_i` into `priv_o` on the next edge. An exception in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_valid_i | input | 1 | Exception pulse |
| exc_cause_i | input | CAUSE_W | Exception cause code |
| exc_epc_i | input | XLEN | PC of the excepting instruction |
| bad_valid_i | input | 1 | Faulting address present |
| bad_addr_i | input | XLEN | Faulting address |
| cur_pc_i | input | XLEN | Current fetch PC |
| ebreak_en_i | input | 4 | Breakpoint-to-debug enable per privilege (bit = privilege code) |
| medeleg_i | input | 2**CAUSE_W | Delegation bit per cause |
| stvec_i | input | XLEN | Supervisor trap vector |
| mtvec_we_i | input | 1 | Machine trap vector write enable |
| mtvec_wdata_i | input | XLEN | Machine trap vector write data |
| priv_we_i | input | 1 | Privilege load enable |
| priv_wdata_i | input | 2 | Privilege load value |
| redirect_o | output | 1 | One-cycle redirect strobe |
| pc_o | output | XLEN | Redirect target PC |
| priv_o | output | 2 | Current privilege |
| mtvec_o | output | XLEN | Machine trap vector |
| dbg_cause_o | output | 3 | Debug cause |
| dbg_prv_o | output | 2 | Privilege saved on debug entry |
| dpc_o | output | XLEN | Debug PC |
| mepc_o | output | XLEN | Machine exception PC |
| mcause_o | output | CAUSE_W | Machine cause |
| mbadaddr_o | output | XLEN | Machine faulting address |
| sepc_o | output | XLEN | Supervisor exception PC |
| scause_o | output | CAUSE_W | Supervisor cause |
| sbadaddr_o | output | XLEN | Supervisor faulting address |

## Verification
Every result of an exception, a trap-vector write or a privilege load is registered once, so it is due exactly one cycle after the edge that samples the stimulus. The redirect strobe must be gone again one cycle after that. The bench changes inputs on the falling edge and reads outputs on the following falling edge. It then looks one more cycle later to confirm that the strobe has dropped and the PC is held. For debug-mode cases, a second exception follows immediately and is read on the next falling edge.

// File: rtl/trap_ctl_pkg.sv
package trap_ctl_pkg;

    localparam logic [1:0] PRV_U = 2'd0;
    localparam logic [1:0] PRV_S = 2'd1;
    localparam logic [1:0] PRV_H = 2'd2;
    localparam logic [1:0] PRV_M = 2'd3;

    localparam logic [2:0] DBG_CAUSE_NONE = 3'd0;
    localparam logic [2:0] DBG_CAUSE_SWBP = 3'd1;

    typedef enum logic [2:0] {
        PATH_NONE      = 3'd0,
        PATH_DBG_ENTRY = 3'd1,
        PATH_DBG_EXC   = 3'd2,
        PATH_MTRAP     = 3'd3,
        PATH_STRAP     = 3'd4
    } path_e;

endpackage

// File: rtl/trap_path_sel.sv
module trap_path_sel
    import trap_ctl_pkg::*;
#(
    parameter int CAUSE_W   = 4,
    parameter int BRK_CAUSE = 3
) (
    input  logic                       exc_valid_i,
    input  logic [CAUSE_W-1:0]         cause_i,
    input  logic [1:0]                 priv_i,
    input  logic [3:0]                 ebreak_en_i,
    input  logic                       dbg_active_i,
    input  logic [(1<<CAUSE_W)-1:0]    medeleg_i,
    output path_e                      path_o
);
    localparam logic [CAUSE_W-1:0] BRK_CODE = CAUSE_W'(BRK_CAUSE);

    logic is_brk_en;
    logic below_m;

    always_comb begin
        is_brk_en = (cause_i == BRK_CODE) && ebreak_en_i[priv_i];
        below_m   = (priv_i == PRV_S) || (priv_i == PRV_U);
        path_o    = PATH_NONE;
        if (exc_valid_i) begin
            if (is_brk_en) begin
                path_o = PATH_DBG_ENTRY;
            end else if (dbg_active_i) begin
                path_o = PATH_DBG_EXC;
            end else if (medeleg_i[cause_i] && below_m) begin
                path_o = PATH_STRAP;
            end else begin
                path_o = PATH_MTRAP;
            end
        end
    end

endmodule

// File: rtl/trap_save_bank.sv
module trap_save_bank #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [XLEN-1:0]    epc_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic               bad_valid_i,
    input  logic [XLEN-1:0]    bad_i,
    output logic [XLEN-1:0]    epc_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [XLEN-1:0]    bad_o
);
    typedef struct packed {
        logic [XLEN-1:0]    epc;
        logic [CAUSE_W-1:0] cause;
        logic [XLEN-1:0]    bad;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we_i) begin
            bank_d.epc   = epc_i;
            bank_d.cause = cause_i;
            if (bad_valid_i) begin
                bank_d.bad = bad_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign epc_o   = bank_q.epc;
    assign cause_o = bank_q.cause;
    assign bad_o   = bank_q.bad;

endmodule

// File: rtl/trap_debug_entry.sv
module trap_debug_entry
    import trap_ctl_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter int          CAUSE_W   = 4,
    parameter int          BRK_CAUSE = 3,
    parameter logic [31:0] RESET_VEC = 32'h0000_1000,
    parameter logic [31:0] MTVEC_DEF = 32'h0000_0100,
    parameter logic [31:0] DBG_START = 32'h0000_0800,
    parameter logic [31:0] DBG_EXC   = 32'h0000_0808
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     exc_valid_i,
    input  logic [CAUSE_W-1:0]       exc_cause_i,
    input  logic [XLEN-1:0]          exc_epc_i,
    input  logic                     bad_valid_i,
    input  logic [XLEN-1:0]          bad_addr_i,
    input  logic [XLEN-1:0]          cur_pc_i,
    input  logic [3:0]               ebreak_en_i,
    input  logic [(1<<CAUSE_W)-1:0]  medeleg_i,
    input  logic [XLEN-1:0]          stvec_i,
    input  logic                     mtvec_we_i,
    input  logic [XLEN-1:0]          mtvec_wdata_i,
    input  logic                     priv_we_i,
    input  logic [1:0]               priv_wdata_i,
    output logic                     redirect_o,
    output logic [XLEN-1:0]          pc_o,
    output logic [1:0]               priv_o,
    output logic [XLEN-1:0]          mtvec_o,
    output logic [2:0]               dbg_cause_o,
    output logic [1:0]               dbg_prv_o,
    output logic [XLEN-1:0]          dpc_o,
    output logic [XLEN-1:0]          mepc_o,
    output logic [CAUSE_W-1:0]       mcause_o,
    output logic [XLEN-1:0]          mbadaddr_o,
    output logic [XLEN-1:0]          sepc_o,
    output logic [CAUSE_W-1:0]       scause_o,
    output logic [XLEN-1:0]          sbadaddr_o
);
    localparam int NBANK  = 2;
    localparam int BANK_M = 0;
    localparam int BANK_S = 1;

    localparam logic [XLEN-1:0] RST_PC   = XLEN'(RESET_VEC);
    localparam logic [XLEN-1:0] RST_TVEC = XLEN'(MTVEC_DEF);
    localparam logic [XLEN-1:0] DROM_GO  = XLEN'(DBG_START);
    localparam logic [XLEN-1:0] DROM_EX  = XLEN'(DBG_EXC);

    typedef struct packed {
        logic              redirect;
        logic [XLEN-1:0]   pc;
        logic [1:0]        priv;
        logic [XLEN-1:0]   mtvec;
        logic [2:0]        dcause;
        logic [1:0]        dprv;
        logic [XLEN-1:0]   dpc;
    } core_t;

    core_t  st_d, st_q;
    path_e  path;

    logic [NBANK-1:0]    bank_we;
    logic [XLEN-1:0]     bank_epc   [NBANK];
    logic [CAUSE_W-1:0]  bank_cause [NBANK];
    logic [XLEN-1:0]     bank_bad   [NBANK];

    trap_path_sel #(
        .CAUSE_W   (CAUSE_W),
        .BRK_CAUSE (BRK_CAUSE)
    ) u_sel (
        .exc_valid_i  (exc_valid_i),
        .cause_i      (exc_cause_i),
        .priv_i       (st_q.priv),
        .ebreak_en_i  (ebreak_en_i),
        .dbg_active_i (st_q.dcause != DBG_CAUSE_NONE),
        .medeleg_i    (medeleg_i),
        .path_o       (path)
    );

    always_comb begin
        bank_we         = '0;
        bank_we[BANK_M] = (path == PATH_MTRAP);
        bank_we[BANK_S] = (path == PATH_STRAP);
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        trap_save_bank #(
            .XLEN    (XLEN),
            .CAUSE_W (CAUSE_W)
        ) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .we_i        (bank_we[g]),
            .epc_i       (exc_epc_i),
            .cause_i     (exc_cause_i),
            .bad_valid_i (bad_valid_i),
            .bad_i       (bad_addr_i),
            .epc_o       (bank_epc[g]),
            .cause_o     (bank_cause[g]),
            .bad_o       (bank_bad[g])
        );
    end

    always_comb begin
        st_d          = st_q;
        st_d.redirect = 1'b0;
        if (priv_we_i) begin
            st_d.priv = priv_wdata_i;
        end
        if (mtvec_we_i) begin
            st_d.mtvec = {mtvec_wdata_i[XLEN-1:2], 2'b00};
        end
        unique case (path)
            PATH_DBG_ENTRY: begin
                st_d.redirect = 1'b1;
                st_d.dcause   = DBG_CAUSE_SWBP;
                st_d.dprv     = st_q.priv;
                st_d.priv     = PRV_M;
                st_d.dpc      = cur_pc_i;
                st_d.pc       = DROM_GO;
            end
            PATH_DBG_EXC: begin
                st_d.redirect = 1'b1;
                st_d.priv     = st_q.priv;
                st_d.pc       = DROM_EX;
            end
            PATH_MTRAP: begin
                st_d.redirect = 1'b1;
                st_d.priv     = PRV_M;
                st_d.pc       = st_q.mtvec;
            end
            PATH_STRAP: begin
                st_d.redirect = 1'b1;
                st_d.priv     = PRV_S;
                st_d.pc       = stvec_i;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.redirect <= 1'b0;
            st_q.pc       <= RST_PC;
            st_q.priv     <= PRV_M;
            st_q.mtvec    <= RST_TVEC;
            st_q.dcause   <= DBG_CAUSE_NONE;
            st_q.dprv     <= PRV_U;
            st_q.dpc      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign redirect_o  = st_q.redirect;
    assign pc_o        = st_q.pc;
    assign priv_o      = st_q.priv;
    assign mtvec_o     = st_q.mtvec;
    assign dbg_cause_o = st_q.dcause;
    assign dbg_prv_o   = st_q.dprv;
    assign dpc_o       = st_q.dpc;
    assign mepc_o      = bank_epc[BANK_M];
    assign mcause_o    = bank_cause[BANK_M];
    assign mbadaddr_o  = bank_bad[BANK_M];
    assign sepc_o      = bank_epc[BANK_S];
    assign scause_o    = bank_cause[BANK_S];
    assign sbadaddr_o  = bank_bad[BANK_S];

endmodule

// File: rtl/trap_debug_entry_chk.sv
module trap_debug_entry_chk
    import trap_ctl_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter int          CAUSE_W   = 4,
    parameter int          BRK_CAUSE = 3,
    parameter logic [31:0] DBG_START = 32'h0000_0800,
    parameter logic [31:0] DBG_EXC   = 32'h0000_0808
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     exc_valid_i,
    input  logic [CAUSE_W-1:0]       exc_cause_i,
    input  logic [XLEN-1:0]          exc_epc_i,
    input  logic [XLEN-1:0]          cur_pc_i,
    input  logic [3:0]               ebreak_en_i,
    input  logic [(1<<CAUSE_W)-1:0]  medeleg_i,
    input  logic                     priv_we_i,
    input  logic                     redirect_o,
    input  logic [XLEN-1:0]          pc_o,
    input  logic [1:0]               priv_o,
    input  logic [2:0]               dbg_cause_o,
    input  logic [1:0]               dbg_prv_o,
    input  logic [XLEN-1:0]          dpc_o,
    input  logic [XLEN-1:0]          mepc_o,
    input  logic [CAUSE_W-1:0]       mcause_o,
    input  logic [XLEN-1:0]          sepc_o
);
    logic brk_hit;
    logic in_dbg;
    assign brk_hit = (exc_cause_i == CAUSE_W'(BRK_CAUSE)) && ebreak_en_i[priv_o];
    assign in_dbg  = (dbg_cause_o != 3'd0);

    AST_REDIRECT_AFTER_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_i |=> redirect_o); // R2

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_valid_i && !priv_we_i) |=> (!redirect_o && $stable(pc_o) && $stable(priv_o))); // R2

    AST_BRK_ENTERS_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_i && brk_hit) |=> (pc_o == XLEN'(DBG_START) && priv_o == PRV_M
            && dbg_cause_o == DBG_CAUSE_SWBP && dbg_prv_o == $past(priv_o)
            && dpc_o == $past(cur_pc_i) && $stable(mepc_o) && $stable(sepc_o))); // R3

    AST_DBG_EXC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_i && in_dbg && !brk_hit) |=> (pc_o == XLEN'(DBG_EXC)
            && $stable(priv_o) && $stable(dpc_o) && $stable(dbg_prv_o)
            && $stable(mepc_o) && $stable(sepc_o))); // R5

    AST_DBG_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        in_dbg |=> (dbg_cause_o != 3'd0)); // R5

    AST_MMODE_TRAP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_i && !in_dbg && !brk_hit && priv_o == PRV_M)
            |=> (priv_o == PRV_M && mepc_o == $past(exc_epc_i) && mcause_o == $past(exc_cause_i))); // R6

    AST_DELEG_KEEPS_MBANK: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_i && !in_dbg && !brk_hit && medeleg_i[exc_cause_i]
            && (priv_o == PRV_S || priv_o == PRV_U))
            |=> (priv_o == PRV_S && $stable(mepc_o) && $stable(mcause_o)
                 && sepc_o == $past(exc_epc_i))); // R7

endmodule

bind trap_debug_entry trap_debug_entry_chk #(
    .XLEN      (XLEN),
    .CAUSE_W   (CAUSE_W),
    .BRK_CAUSE (BRK_CAUSE),
    .DBG_START (DBG_START),
    .DBG_EXC   (DBG_EXC)
) u_chk (.*);

// File: tb/sim_trap_debug_entry.sv
`timescale 1ns/1ps
module sim_trap_debug_entry;

    localparam logic [31:0] RST_PC   = 32'h0000_1000;
    localparam logic [31:0] TVEC_DEF = 32'h0000_0100;
    localparam logic [31:0] DGO      = 32'h0000_0800;
    localparam logic [31:0] DEX      = 32'h0000_0808;
    localparam logic [31:0] STVEC    = 32'h0000_2200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid_i = 1'b0;
    logic [3:0]  exc_cause_i = '0;
    logic [31:0] exc_epc_i = '0;
    logic        bad_valid_i = 1'b0;
    logic [31:0] bad_addr_i = '0;
    logic [31:0] cur_pc_i = '0;
    logic [3:0]  ebreak_en_i = '0;
    logic [15:0] medeleg_i = '0;
    logic [31:0] stvec_i = STVEC;
    logic        mtvec_we_i = 1'b0;
    logic [31:0] mtvec_wdata_i = '0;
    logic        priv_we_i = 1'b0;
    logic [1:0]  priv_wdata_i = '0;
    logic        redirect_o;
    logic [31:0] pc_o, mtvec_o, dpc_o, mepc_o, mbadaddr_o, sepc_o, sbadaddr_o;
    logic [1:0]  priv_o, dbg_prv_o;
    logic [2:0]  dbg_cause_o;
    logic [3:0]  mcause_o, scause_o;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    trap_debug_entry u0 (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        exc_valid_i = 1'b0; mtvec_we_i = 1'b0; priv_we_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic fire(input logic [3:0] cause, input logic [31:0] epc,
                        input logic [31:0] cur, input logic bv, input logic [31:0] bad);
        exc_valid_i = 1'b1; exc_cause_i = cause; exc_epc_i = epc;
        cur_pc_i = cur; bad_valid_i = bv; bad_addr_i = bad;
        @(negedge clk);
        exc_valid_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        do_reset();
        chk("R1", "pc", pc_o, RST_PC);
        chk("R1", "priv", 32'(priv_o), 32'd3);
        chk("R1", "mtvec", mtvec_o, TVEC_DEF);
        chk("R1", "dbg_cause", 32'(dbg_cause_o), 32'd0);
        chk("R1", "redirect", 32'(redirect_o), 32'd0);
        chk("R1", "dpc", dpc_o, 32'd0);
        chk("R1", "mepc", mepc_o, 32'd0);
        chk("R1", "sepc", sepc_o, 32'd0);

        // Sweep over privilege, cause, delegation, enable and bad-address flag
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 16; c++) begin
                for (int m = 0; m < 8; m++) begin
                    logic        deleg, en, bv, dbg_path, s_path;
                    logic [31:0] tvec, epc, cur, bad, exp_pc, exp_bad;
                    deleg = m[0]; en = m[1]; bv = m[2];
                    tvec = 32'h0000_3000 | 32'(c << 4);
                    epc  = 32'h0000_4000 | 32'(c << 4) | 32'(p << 2);
                    cur  = 32'h0000_5000 | 32'(c << 4) | 32'(m);
                    bad  = 32'hBAD0_0000 | 32'(p << 8) | 32'(c << 4) | 32'(m);
                    do_reset();
                    mtvec_we_i = 1'b1; mtvec_wdata_i = tvec | 32'h3;
                    @(negedge clk);
                    mtvec_we_i = 1'b0;
                    chk("R9", "mtvec low bits cleared", mtvec_o, tvec);
                    priv_we_i = 1'b1; priv_wdata_i = 2'(p);
                    @(negedge clk);
                    priv_we_i = 1'b0;
                    chk("R10", "priv load", 32'(priv_o), 32'(p));
                    medeleg_i   = deleg ? (16'h1 << c) : ~(16'h1 << c);
                    ebreak_en_i = en ? (4'h1 << p) : ~(4'h1 << p);
                    dbg_path = (c == 3) && en;
                    s_path   = !dbg_path && deleg && (p <= 1);
                    fire(4'(c), epc, cur, bv, bad);
                    chk("R2", "redirect high", 32'(redirect_o), 32'd1);
                    exp_bad = bv ? bad : 32'd0;
                    if (dbg_path) begin
                        chk("R3", "pc", pc_o, DGO);
                        chk("R3", "priv", 32'(priv_o), 32'd3);
                        chk("R3", "dbg_cause", 32'(dbg_cause_o), 32'd1);
                        chk("R3", "dbg_prv", 32'(dbg_prv_o), 32'(p));
                        chk("R3", "dpc", dpc_o, cur);
                        chk("R3", "mepc untouched", mepc_o, 32'd0);
                        chk("R3", "sepc untouched", sepc_o, 32'd0);
                        // second exception while in debug mode
                        ebreak_en_i = 4'h0;
                        fire(4'd2, 32'h0000_6000, 32'h0000_6100, 1'b1, 32'hFEED_0000);
                        chk("R5", "pc", pc_o, DEX);
                        chk("R5", "priv", 32'(priv_o), 32'd3);
                        chk("R5", "dbg_cause", 32'(dbg_cause_o), 32'd1);
                        chk("R5", "dbg_prv", 32'(dbg_prv_o), 32'(p));
                        chk("R5", "dpc", dpc_o, cur);
                        chk("R5", "mepc", mepc_o, 32'd0);
                        chk("R5", "mbadaddr", mbadaddr_o, 32'd0);
                        chk("R5", "sepc", sepc_o, 32'd0);
                        exp_pc = DEX;
                    end else if (s_path) begin
                        chk("R7", "pc", pc_o, STVEC);
                        chk("R7", "priv", 32'(priv_o), 32'd1);
                        chk("R7", "sepc", sepc_o, epc);
                        chk("R7", "scause", 32'(scause_o), 32'(c));
                        chk("R7", "sbadaddr", sbadaddr_o, exp_bad);
                        chk("R7", "mepc untouched", mepc_o, 32'd0);
                        chk("R7", "mcause untouched", 32'(mcause_o), 32'd0);
                        exp_pc = STVEC;
                    end else begin
                        // R4 covers breakpoint causes with the enable clear
                        chk((c == 3) ? "R4" : "R6", "pc", pc_o, tvec);
                        chk("R6", "priv", 32'(priv_o), 32'd3);
                        chk("R6", "mepc", mepc_o, epc);
                        chk("R6", "mcause", 32'(mcause_o), 32'(c));
                        chk("R6", "mbadaddr", mbadaddr_o, exp_bad);
                        chk("R6", "sepc untouched", sepc_o, 32'd0);
                        chk("R6", "dbg_cause", 32'(dbg_cause_o), 32'd0);
                        exp_pc = tvec;
                    end
                    @(negedge clk);
                    chk("R2", "redirect drops", 32'(redirect_o), 32'd0);
                    chk("R2", "pc held", pc_o, exp_pc);
                end
            end
        end

        // R8: breakpoint again while in debug mode re-enters
        do_reset();
        ebreak_en_i = 4'b1000; medeleg_i = '0;
        fire(4'd3, 32'h0000_A000, 32'h0000_A004, 1'b0, 32'd0);
        chk("R8", "first entry dpc", dpc_o, 32'h0000_A004);
        fire(4'd3, 32'h0000_B000, 32'h0000_B004, 1'b0, 32'd0);
        chk("R8", "re-entry pc", pc_o, DGO);
        chk("R8", "re-entry dpc", dpc_o, 32'h0000_B004);
        chk("R8", "re-entry dbg_prv", 32'(dbg_prv_o), 32'd3);
        chk("R8", "re-entry redirect", 32'(redirect_o), 32'd1);

        // R9: trap in same cycle as vector write uses old vector
        do_reset();
        ebreak_en_i = 4'h0; medeleg_i = '0;
        mtvec_we_i = 1'b1; mtvec_wdata_i = 32'h0000_7777;
        fire(4'd5, 32'h0000_C000, 32'h0000_C000, 1'b0, 32'd0);
        mtvec_we_i = 1'b0;
        chk("R9", "trap uses old vector", pc_o, TVEC_DEF);
        chk("R9", "vector written", mtvec_o, 32'h0000_7774);

        // R10: exception wins over privilege load in same cycle
        do_reset();
        medeleg_i = 16'hFFFF;
        priv_we_i = 1'b1; priv_wdata_i = 2'd0;
        fire(4'd2, 32'h0000_D000, 32'h0000_D000, 1'b0, 32'd0);
        priv_we_i = 1'b0;
        chk("R10", "exception wins priv", 32'(priv_o), 32'd3);
        chk("R10", "exception wins pc", pc_o, TVEC_DEF);

        // R7: hypervisor level is not delegated
        do_reset();
        priv_we_i = 1'b1; priv_wdata_i = 2'd2;
        @(negedge clk);
        priv_we_i = 1'b0;
        fire(4'd7, 32'h0000_E000, 32'h0000_E000, 1'b0, 32'd0);
        chk("R7", "H level stays M priv", 32'(priv_o), 32'd3);
        chk("R7", "H level stays M epc", mepc_o, 32'h0000_E000);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule